// File: doc/BRIEF.md
# Dual-Clock Reconfigurable Line-Delay Buffer

This block is a line memory that sits between a producer and a consumer running on unrelated clocks. A write pointer advances on the write clock and a read pointer advances on the read clock. Each pointer counts freely and wraps at the end of the line. The buffer has no full or empty flag. The delay between a sample going in and coming out is set by how far apart the two pointer resets were issued. A typical use is a one-line delay for raster data.

The storage is made of two half-width banks of equal depth. In word mode the two banks work side by side and hold `LINE_WORDS` full-width words. In byte mode they are chained end to end and hold `2*LINE_WORDS` half-width entries. A full-size line is 5,048 words, or 10,096 bytes; the default parameter is smaller. The mode must be changed only while the buffer is idle, and both pointer resets must follow a change. The output is forced to zero when the output enable is high, which stands in for a high-impedance pin, and a separate flag shows when the output would be driven.

Top module: `lbuf_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, both pointers are zero and the registered read data is zero. With `oen_n` low and no read performed, `dout` reads 0.
- R2: When `wr_zero_n=1` and `wen_n=0`, the `din` value is stored at the write pointer on the rising `wclk` edge, and the pointer then moves up by one.
- R3: When `wr_zero_n=1` and `wen_n=1` at a rising `wclk` edge, nothing is stored and the write pointer keeps its value.
- R4: When `rd_zero_n=1` and `ren_n=0` at a rising `rclk` edge, the entry at the read pointer is loaded into the output register and the pointer moves up by one. When `ren_n=1`, both the output register and the pointer hold.
- R5: When `oen_n=1`, `dout` is all zeros and `dout_oe=0`. When `oen_n=0`, `dout_oe=1` and `dout` shows the registered read data, which the enable does not disturb.
- R6: With `mode_byte=0`, a pointer at address `LINE_WORDS-1` wraps to 0 on its next step.
- R7: With `mode_byte=1`, the line holds `2*LINE_WORDS` entries. Only `din[7:0]` is stored. Addresses `0..LINE_WORDS-1` fall in the lower bank and the rest in the upper bank. `dout[15:8]` is zero. The pointers wrap from `2*LINE_WORDS-1` to 0.
- R8: `wr_zero_n=0` at a rising `wclk` edge sets the write pointer to 0 and performs no write. `rd_zero_n=0` at a rising `rclk` edge sets the read pointer to 0 and performs no read. Both act whatever the level of `wen_n`, `ren_n` or `oen_n`.
- R9: When both sides stream continuously and the write reset leads the read reset by D enabled write edges, with D at least the minimum offset, the k-th read returns the k-th word written. This holds across line wraps.
- R10: With `mode_byte=0`, all 16 bits of `din` are stored and returned on `dout[15:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| wclk | input | 1 | Write clock |
| wr_zero_n | input | 1 | Synchronous write-pointer reset, active low |
| wen_n | input | 1 | Write enable, active low |
| din | input | 16 | Write data |
| rclk | input | 1 | Read clock |
| rd_zero_n | input | 1 | Synchronous read-pointer reset, active low |
| ren_n | input | 1 | Read enable, active low |
| oen_n | input | 1 | Output enable, active low |
| mode_byte | input | 1 | Organisation: 0 = word mode, 1 = byte mode |
| dout | output | 16 | Read data, zero while the output is disabled |
| dout_oe | output | 1 | High when the output would be driven |

## Verification
The bench builds the block with `LINE_WORDS=12`. This line length is not a power of two, so the wrap compare is tested at an address that a plain binary rollover would miss. It also means that line-long runs, such as 15 words in word mode or 26 bytes in byte mode, exercise wraps in both organisations within a few hundred cycles. The streaming test runs the two clocks at the same rate with a fixed phase skew and uses a minimum pointer offset of 4. With these settings, 20 reads cross the 12-entry wrap while the writer stays ahead.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  typedef enum logic {
    ORG_WORD = 1'b0,
    ORG_BYTE = 1'b1
  } org_e;
endpackage

// File: rtl/lbuf_rst_sync.sv
module lbuf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/lbuf_ptr.sv
module lbuf_ptr
  import lbuf_pkg::*;
#(
  parameter int LINE_WORDS = 1024,
  parameter int AW         = 11
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          zero_n,
  input  logic          step_n,
  input  org_e          org,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] END_WORD = AW'(LINE_WORDS - 1);
  localparam logic [AW-1:0] END_BYTE = AW'(2 * LINE_WORDS - 1);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          at_end;

  always_comb begin
    at_end = (org == ORG_BYTE) ? (ptr_q == END_BYTE) : (ptr_q == END_WORD);
    ptr_d  = ptr_q;
    if (!zero_n)      ptr_d = '0;
    else if (!step_n) ptr_d = at_end ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/lbuf_bank.sv
module lbuf_bank #(
  parameter int DW    = 8,
  parameter int DEPTH = 1024,
  parameter int BAW   = 10
) (
  input  logic           wclk,
  input  logic           we,
  input  logic [BAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic           rclk,
  input  logic           rsrst_n,
  input  logic           re,
  input  logic [BAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rsrst_n) begin
    if (!rsrst_n) rdata_q <= '0;
    else if (re)  rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/lbuf_top.sv
module lbuf_top
  import lbuf_pkg::*;
#(
  parameter int LINE_WORDS = 1024,
  parameter int WORD_W     = 16
) (
  input  logic              rst_n,
  input  logic              wclk,
  input  logic              wr_zero_n,
  input  logic              wen_n,
  input  logic [WORD_W-1:0] din,
  input  logic              rclk,
  input  logic              rd_zero_n,
  input  logic              ren_n,
  input  logic              oen_n,
  input  logic              mode_byte,
  output logic [WORD_W-1:0] dout,
  output logic              dout_oe
);
  localparam int HALF_W = WORD_W / 2;
  localparam int AW     = $clog2(2 * LINE_WORDS);
  localparam int BAW    = AW - 1;
  localparam logic [AW-1:0] LINE_A = AW'(LINE_WORDS);

  org_e org;
  assign org = org_e'(mode_byte);

  // per-domain reset release
  logic w_srst_n, r_srst_n;
  lbuf_rst_sync wsync_i (.clk(wclk), .arst_n(rst_n), .srst_n(w_srst_n));
  lbuf_rst_sync rsync_i (.clk(rclk), .arst_n(rst_n), .srst_n(r_srst_n));

  // free-running line pointers
  logic [AW-1:0] wptr, rptr;
  lbuf_ptr #(.LINE_WORDS(LINE_WORDS), .AW(AW)) wptr_i (
    .clk(wclk), .srst_n(w_srst_n), .zero_n(wr_zero_n), .step_n(wen_n),
    .org(org), .ptr(wptr));
  lbuf_ptr #(.LINE_WORDS(LINE_WORDS), .AW(AW)) rptr_i (
    .clk(rclk), .srst_n(r_srst_n), .zero_n(rd_zero_n), .step_n(ren_n),
    .org(org), .ptr(rptr));

  // a pointer reset blocks the access in the same cycle
  logic wr_go, rd_go;
  assign wr_go = wr_zero_n & ~wen_n;
  assign rd_go = rd_zero_n & ~ren_n;

  // bank selection and in-bank offset (upper half only reachable in byte mode)
  logic           w_hi, r_hi;
  logic [BAW-1:0] w_off, r_off;
  always_comb begin
    w_hi  = (wptr >= LINE_A);
    r_hi  = (rptr >= LINE_A);
    w_off = BAW'(w_hi ? wptr - LINE_A : wptr);
    r_off = BAW'(r_hi ? rptr - LINE_A : rptr);
  end

  logic [HALF_W-1:0] bank_wd [2];
  logic [HALF_W-1:0] bank_rd [2];
  logic [1:0]        bank_we;

  always_comb begin
    bank_wd[0] = din[HALF_W-1:0];
    bank_wd[1] = (org == ORG_BYTE) ? din[HALF_W-1:0] : din[WORD_W-1:HALF_W];
    bank_we[0] = wr_go & ((org == ORG_WORD) | ~w_hi);
    bank_we[1] = wr_go & ((org == ORG_WORD) |  w_hi);
  end

  generate
    for (genvar gb = 0; gb < 2; gb++) begin : g_bank
      lbuf_bank #(.DW(HALF_W), .DEPTH(LINE_WORDS), .BAW(BAW)) bank_i (
        .wclk   (wclk),
        .we     (bank_we[gb]),
        .waddr  (w_off),
        .wdata  (bank_wd[gb]),
        .rclk   (rclk),
        .rsrst_n(r_srst_n),
        .re     (rd_go),
        .raddr  (r_off),
        .rdata  (bank_rd[gb]));
    end
  endgenerate

  // remember which bank the last byte-mode read came from
  logic r_sel_q, r_sel_d;
  always_comb r_sel_d = rd_go ? r_hi : r_sel_q;

  always_ff @(posedge rclk or negedge r_srst_n) begin
    if (!r_srst_n) r_sel_q <= 1'b0;
    else           r_sel_q <= r_sel_d;
  end

  logic [WORD_W-1:0] rd_raw, rd_word;
  always_comb begin
    rd_raw = {bank_rd[1], bank_rd[0]};
    if (org == ORG_BYTE)
      rd_word = {{HALF_W{1'b0}}, (r_sel_q ? bank_rd[1] : bank_rd[0])};
    else
      rd_word = rd_raw;
  end

  assign dout    = oen_n ? '0 : rd_word;
  assign dout_oe = ~oen_n;
endmodule

// File: rtl/lbuf_chk.sv
module lbuf_chk #(
  parameter int LINE_WORDS = 1024,
  parameter int WORD_W     = 16,
  parameter int AW         = 11
) (
  input logic              wclk,
  input logic              rclk,
  input logic              w_srst_n,
  input logic              r_srst_n,
  input logic              wr_zero_n,
  input logic              wen_n,
  input logic              rd_zero_n,
  input logic              ren_n,
  input logic              mode_byte,
  input logic [AW-1:0]     wptr,
  input logic [AW-1:0]     rptr,
  input logic [WORD_W-1:0] rd_raw,
  input logic [WORD_W-1:0] dout
);
  logic [AW-1:0] w_end;
  assign w_end = mode_byte ? AW'(2 * LINE_WORDS - 1) : AW'(LINE_WORDS - 1);

  // R2
  wptr_step_chk: assert property (@(posedge wclk) disable iff (!w_srst_n)
    (wr_zero_n && !wen_n && wptr != w_end) |=> (wptr == $past(wptr) + 1'b1));

  // R6
  wptr_wrap_chk: assert property (@(posedge wclk) disable iff (!w_srst_n)
    (wr_zero_n && !wen_n && wptr == w_end) |=> (wptr == '0));

  // R3
  wptr_hold_chk: assert property (@(posedge wclk) disable iff (!w_srst_n)
    (wr_zero_n && wen_n) |=> $stable(wptr));

  // R8
  wptr_zero_chk: assert property (@(posedge wclk) disable iff (!w_srst_n)
    !wr_zero_n |=> (wptr == '0));

  // R8
  rptr_zero_chk: assert property (@(posedge rclk) disable iff (!r_srst_n)
    !rd_zero_n |=> (rptr == '0));

  // R4
  rptr_hold_chk: assert property (@(posedge rclk) disable iff (!r_srst_n)
    (rd_zero_n && ren_n) |=> $stable(rptr));

  // R4
  rdata_hold_chk: assert property (@(posedge rclk) disable iff (!r_srst_n)
    (!rd_zero_n || ren_n) |=> $stable(rd_raw));

  // R7
  byte_upper_zero_chk: assert property (@(posedge rclk) disable iff (!r_srst_n)
    mode_byte |-> (dout[WORD_W-1:WORD_W/2] == '0));
endmodule

bind lbuf_top lbuf_chk #(.LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W), .AW(AW)) chk_i (
  .wclk(wclk), .rclk(rclk), .w_srst_n(w_srst_n), .r_srst_n(r_srst_n),
  .wr_zero_n(wr_zero_n), .wen_n(wen_n), .rd_zero_n(rd_zero_n), .ren_n(ren_n),
  .mode_byte(mode_byte), .wptr(wptr), .rptr(rptr), .rd_raw(rd_raw), .dout(dout));

// File: tb/lbuf_top_tb.sv
module lbuf_top_tb_top;
  localparam int L          = 12;
  localparam int MIN_OFFSET = 4;

  logic        rst_n, wclk, rclk;
  logic        wr_zero_n, wen_n, rd_zero_n, ren_n, oen_n, mode_byte;
  logic [15:0] din, dout;
  logic        dout_oe;

  int checks = 0;
  int errors = 0;

  lbuf_top #(.LINE_WORDS(L), .WORD_W(16)) dut_i (
    .rst_n(rst_n), .wclk(wclk), .wr_zero_n(wr_zero_n), .wen_n(wen_n), .din(din),
    .rclk(rclk), .rd_zero_n(rd_zero_n), .ren_n(ren_n), .oen_n(oen_n),
    .mode_byte(mode_byte), .dout(dout), .dout_oe(dout_oe));

  initial begin
    wclk = 1'b0;
    forever #10 wclk = ~wclk;
  end

  initial begin
    rclk = 1'b0;
    #5;
    forever #10 rclk = ~rclk;
  end

  function automatic logic [15:0] wval(input int i);
    return 16'(16'h5A00 + i * 16'h0137);
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic w_cycle(input logic zn, input logic en_n, input logic [15:0] d);
    @(negedge wclk);
    wr_zero_n = zn;
    wen_n     = en_n;
    din       = d;
    @(posedge wclk);
    #1;
    wr_zero_n = 1'b1;
    wen_n     = 1'b1;
  endtask

  task automatic r_cycle(input logic zn, input logic en_n, output logic [15:0] q);
    @(negedge rclk);
    rd_zero_n = zn;
    ren_n     = en_n;
    @(posedge rclk);
    #2;
    q         = dout;
    rd_zero_n = 1'b1;
    ren_n     = 1'b1;
  endtask

  task automatic t_reset;
    logic [15:0] q;
    rst_n = 1'b0; wr_zero_n = 1'b1; wen_n = 1'b1; rd_zero_n = 1'b1; ren_n = 1'b1;
    oen_n = 1'b0; mode_byte = 1'b0; din = '0;
    repeat (3) @(posedge wclk);
    #3;
    check("R1 dout in reset", dout, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(posedge rclk);
    r_cycle(1'b1, 1'b1, q);
    check("R1 dout after reset", q, 16'h0000);
    check("R5 oe flag on", {15'd0, dout_oe}, 16'h0001);
  endtask

  task automatic t_word_basic;
    logic [15:0] q;
    w_cycle(1'b0, 1'b1, 16'h0);
    for (int i = 0; i < 6; i++) w_cycle(1'b1, 1'b0, wval(i));
    r_cycle(1'b0, 1'b1, q);
    for (int i = 0; i < 5; i++) begin
      r_cycle(1'b1, 1'b0, q);
      check("R2 R10 word read", q, wval(i));
    end
    for (int i = 0; i < 2; i++) begin
      r_cycle(1'b1, 1'b1, q);
      check("R4 hold on idle", q, wval(4));
    end
    r_cycle(1'b1, 1'b0, q);
    check("R4 pointer held", q, wval(5));
  endtask

  task automatic t_wen_skip;
    logic [15:0] q;
    w_cycle(1'b0, 1'b1, 16'h0);
    w_cycle(1'b1, 1'b0, 16'hA1A1);
    w_cycle(1'b1, 1'b1, 16'hDEAD);
    w_cycle(1'b1, 1'b0, 16'hB2B2);
    r_cycle(1'b0, 1'b1, q);
    r_cycle(1'b1, 1'b0, q);
    check("R3 first word", q, 16'hA1A1);
    r_cycle(1'b1, 1'b0, q);
    check("R3 skipped write", q, 16'hB2B2);
  endtask

  task automatic t_oe;
    #3;
    oen_n = 1'b1;
    #2;
    check("R5 dout off", dout, 16'h0000);
    check("R5 oe flag off", {15'd0, dout_oe}, 16'h0000);
    @(posedge rclk);
    #3;
    oen_n = 1'b0;
    #2;
    check("R5 data kept", dout, 16'hB2B2);
  endtask

  task automatic t_wrap;
    logic [15:0] q;
    w_cycle(1'b0, 1'b1, 16'h0);
    for (int i = 0; i < L + 3; i++) w_cycle(1'b1, 1'b0, wval(100 + i));
    r_cycle(1'b0, 1'b1, q);
    for (int k = 0; k < L; k++) begin
      r_cycle(1'b1, 1'b0, q);
      check("R6 word wrap", q, (k < 3) ? wval(100 + k + L) : wval(100 + k));
    end
    r_cycle(1'b1, 1'b0, q);
    check("R6 read wrap", q, wval(100 + L));
  endtask

  task automatic t_byte;
    logic [15:0] q;
    mode_byte = 1'b1;
    w_cycle(1'b0, 1'b1, 16'h0);
    for (int i = 0; i < 2 * L + 2; i++) w_cycle(1'b1, 1'b0, {8'hEE, 8'(8'h30 + i)});
    r_cycle(1'b0, 1'b1, q);
    for (int k = 0; k < 2 * L; k++) begin
      r_cycle(1'b1, 1'b0, q);
      check("R7 byte depth", q, {8'h00, ((k < 2) ? 8'(8'h30 + k + 2 * L) : 8'(8'h30 + k))});
    end
    r_cycle(1'b1, 1'b0, q);
    check("R7 byte wrap", q, {8'h00, 8'(8'h30 + 2 * L)});
    mode_byte = 1'b0;
  endtask

  task automatic t_reset_override;
    logic [15:0] q;
    w_cycle(1'b0, 1'b1, 16'h0);
    for (int i = 0; i < 4; i++) w_cycle(1'b1, 1'b0, wval(200 + i));
    r_cycle(1'b0, 1'b1, q);
    r_cycle(1'b1, 1'b0, q);
    check("R8 pre read", q, wval(200));
    w_cycle(1'b0, 1'b0, 16'hBAD0);
    w_cycle(1'b1, 1'b0, 16'hC3C3);
    r_cycle(1'b0, 1'b0, q);
    check("R8 read reset no read", q, wval(200));
    r_cycle(1'b1, 1'b0, q);
    check("R8 write ptr zeroed", q, 16'hC3C3);
    for (int k = 1; k < 4; k++) begin
      r_cycle(1'b1, 1'b0, q);
      check("R8 no write on reset", q, wval(200 + k));
    end
  endtask

  task automatic t_delay;
    fork
      begin
        w_cycle(1'b0, 1'b1, 16'h0);
        for (int i = 0; i < 30; i++) w_cycle(1'b1, 1'b0, wval(300 + i));
      end
      begin
        logic [15:0] q;
        @(posedge wclk);
        repeat (MIN_OFFSET + 1) @(posedge wclk);
        r_cycle(1'b0, 1'b1, q);
        for (int k = 0; k < 20; k++) begin
          r_cycle(1'b1, 1'b0, q);
          check("R9 line delay", q, wval(300 + k));
        end
      end
    join
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_word_basic();
    t_wen_skip();
    t_oe();
    t_wrap();
    t_byte();
    t_reset_override();
    t_delay();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule